// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel that sits beside an external free-running timer/counter. On each enabled timer tick it checks the live counter value against its active compare value. On a hit it raises a sticky match flag and acts on a waveform output bit. The action can set, clear or toggle the bit, or leave the output disconnected, as a two-bit output mode field selects. In the clear-on-compare waveform mode the hit also sends a one-cycle clear request back to the counter.

Software reaches the channel through a small register port. In the two PWM waveform modes, compare writes land in a shadow register. The shadow moves into the active register only on a tick that carries the counter's TOP strobe or BOTTOM strobe, whichever the mode picks. This keeps each PWM period whole. In normal and clear-on-compare modes, writes reach the active register at once.

A force strobe in the control register triggers the output action without a real hit. A CPU write to the counter, which the block sees as a strobe, suppresses the next tick's compare.

Top module: `ocu_channel`

## Requirements
- R1: On a cycle with `tick`=1, `cnt` equal to the active compare value, no pending block and no `cnt_wr`, `match_flag` reads 1 after that clock edge. A cycle with `tick`=0 never sets it.
- R2: The output mode field is ctrl bits [1:0], at address 1. On a match, 01 toggles the output bit, 10 clears it and 11 sets it. With 00 the bit is left alone and `wave_out` is driven 0.
- R3: In waveform modes 00 (normal) and 10 (clear-on-compare), a write to address 0 updates the active compare value at once. A read of address 0 returns the active value.
- R4: In waveform mode 01, a write to address 0 goes to the shadow register, and a read of address 0 returns the shadow. The shadow is copied to the active value only on a cycle with `tick`=1 and `at_top`=1.
- R5: In waveform mode 11, the shadow is copied to the active value only on a cycle with `tick`=1 and `at_bottom`=1. A tick with `at_top` does not copy it.
- R6: In modes 00 and 10, writing a control word with bit 2 (force) set applies the action selected by that word's bits [1:0]. A force sets no match flag and raises no `clr_req`. Bit 2 always reads back as 0.
- R7: In modes 01 and 11 the force bit has no effect on the output.
- R8: A `cnt_wr` pulse suppresses the match on the next tick, even when several tick-less cycles pass first. The tick after that one matches normally.
- R9: The output bit keeps its value when `wave_mode` changes.
- R10: A control write changes the output mode at once. This holds in PWM modes too, where the compare value is buffered.
- R11: The match flag is read at address 2, bit 0. Writing 1 there clears it and writing 0 leaves it unchanged. A match in the same cycle as a clearing write wins.
- R12: In mode 10 a real match makes `clr_req` high for exactly the one cycle after the match edge. In other modes `clr_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable |
| cnt | input | 8 | Current counter value |
| at_top | input | 1 | Counter is at TOP |
| at_bottom | input | 1 | Counter is at BOTTOM |
| cnt_wr | input | 1 | CPU is writing the counter this cycle |
| wave_mode | input | 2 | 00 normal, 01 PWM load at TOP, 10 clear-on-compare, 11 PWM load at BOTTOM |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 compare, 1 control, 2 flag |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| match_flag | output | 1 | Compare match interrupt flag |
| wave_out | output | 1 | Waveform output bit |
| clr_req | output | 1 | Counter clear request |

## Verification
Flag, output bit and clear request are each one register away from the edge that samples the tick, write or force. Each is therefore due one cycle after its stimulus. Read data is combinational and is valid in the same cycle as `rd_addr`. The bench drives on the falling edge, lets one rising edge pass and samples on the next falling edge. Shadow-copy and blocking checks step one tick at a time, so each delayed effect lands in a known tick.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    typedef enum logic [1:0] {
        WM_NORMAL  = 2'b00,
        WM_PWM_TOP = 2'b01,
        WM_CTC     = 2'b10,
        WM_PWM_BOT = 2'b11
    } wave_mode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_CLEAR  = 2'b10,
        OM_SET    = 2'b11
    } out_mode_e;

    localparam logic [1:0] ADDR_CMP  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;
    localparam int         FORCE_BIT = 2;

    function automatic logic mode_is_pwm(input logic [1:0] wm);
        return (wm == WM_PWM_TOP) || (wm == WM_PWM_BOT);
    endfunction

    function automatic logic next_level(input logic cur, input out_mode_e om);
        case (om)
            OM_TOGGLE: return ~cur;
            OM_CLEAR:  return 1'b0;
            OM_SET:    return 1'b1;
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/ocu_cmp_buf.sv
module ocu_cmp_buf
    import ocu_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic          at_top,
    input  logic          at_bottom,
    input  logic          cnt_wr,
    input  logic [1:0]    wave_mode,
    input  logic          cmp_wr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] active_q,
    output logic [CW-1:0] shadow_q,
    output logic          blk_q,
    output logic          match
);
    logic pwm;
    logic load_now;

    always_comb begin
        pwm = mode_is_pwm(wave_mode);
        case (wave_mode)
            WM_PWM_TOP: load_now = tick && at_top;
            WM_PWM_BOT: load_now = tick && at_bottom;
            default:    load_now = 1'b0;
        endcase
        match = tick && !blk_q && !cnt_wr && (cnt == active_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
            shadow_q <= '0;
        end else begin
            if (cmp_wr) shadow_q <= wr_data;
            if (cmp_wr && !pwm) active_q <= wr_data;
            else if (load_now)  active_q <= shadow_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         blk_q <= 1'b0;
        else if (cnt_wr) blk_q <= 1'b1;
        else if (tick)   blk_q <= 1'b0;
    end

endmodule

// File: rtl/ocu_wave.sv
module ocu_wave
    import ocu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      match,
    input  logic      force_req,
    input  out_mode_e eff_mode,
    output logic      wave_out
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst)                     level_q <= 1'b0;
        else if (match || force_req) level_q <= next_level(level_q, eff_mode);
    end

    assign wave_out = (eff_mode != OM_OFF) && level_q;

endmodule

// File: rtl/ocu_regs.sv
module ocu_regs
    import ocu_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    input  logic [1:0]    wave_mode,
    input  logic          match,
    input  logic [CW-1:0] active_q,
    input  logic [CW-1:0] shadow_q,
    output logic          cmp_wr,
    output logic          force_req,
    output out_mode_e     eff_mode,
    output logic          flag_q,
    output logic          clr_req,
    output logic [CW-1:0] rd_data
);
    out_mode_e mode_q;
    logic      ctrl_wr;
    logic      flag_clr;

    always_comb begin
        cmp_wr    = wr_en && (wr_addr == ADDR_CMP);
        ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
        flag_clr  = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];
        eff_mode  = ctrl_wr ? out_mode_e'(wr_data[1:0]) : mode_q;
        force_req = ctrl_wr && wr_data[FORCE_BIT] && !mode_is_pwm(wave_mode);
        case (rd_addr)
            ADDR_CMP:  rd_data = mode_is_pwm(wave_mode) ? shadow_q : active_q;
            ADDR_CTRL: rd_data = {{(CW-2){1'b0}}, mode_q};
            ADDR_FLAG: rd_data = {{(CW-1){1'b0}}, flag_q};
            default:   rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= OM_OFF;
            flag_q  <= 1'b0;
            clr_req <= 1'b0;
        end else begin
            if (ctrl_wr) mode_q <= out_mode_e'(wr_data[1:0]);
            if (match)         flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            clr_req <= match && (wave_mode == WM_CTC);
        end
    end

endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
    import ocu_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic          at_top,
    input  logic          at_bottom,
    input  logic          cnt_wr,
    input  logic [1:0]    wave_mode,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    output logic          match_flag,
    output logic          wave_out,
    output logic          clr_req
);
    logic [CW-1:0] active_q;
    logic [CW-1:0] shadow_q;
    logic          blk_q;
    logic          match;
    logic          cmp_wr;
    logic          force_req;
    out_mode_e     eff_mode;

    ocu_cmp_buf #(.CW(CW)) u_cmp (
        .clk(clk), .rst(rst), .tick(tick), .cnt(cnt),
        .at_top(at_top), .at_bottom(at_bottom), .cnt_wr(cnt_wr),
        .wave_mode(wave_mode), .cmp_wr(cmp_wr), .wr_data(wr_data),
        .active_q(active_q), .shadow_q(shadow_q), .blk_q(blk_q), .match(match)
    );

    ocu_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .wave_mode(wave_mode),
        .match(match), .active_q(active_q), .shadow_q(shadow_q),
        .cmp_wr(cmp_wr), .force_req(force_req), .eff_mode(eff_mode),
        .flag_q(match_flag), .clr_req(clr_req), .rd_data(rd_data)
    );

    ocu_wave u_wave (
        .clk(clk), .rst(rst), .match(match), .force_req(force_req),
        .eff_mode(eff_mode), .wave_out(wave_out)
    );

endmodule

// File: rtl/ocu_chk.sv
module ocu_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          cnt_wr,
    input logic [1:0]    wave_mode,
    input logic          at_top,
    input logic          at_bottom,
    input logic          match_flag,
    input logic          clr_req,
    input logic          blk_q,
    input logic [CW-1:0] active_q
);
    // R1
    flag_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> !$rose(match_flag));

    // R8
    blocked_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(blk_q) && $past(tick)) |-> !$rose(match_flag));

    // R12
    clr_only_ctc_chk: assert property (@(posedge clk) disable iff (rst)
        clr_req |-> ($past(wave_mode) == 2'b10));

    // R12
    clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> !clr_req || $past(tick));

    // R4
    pwm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wave_mode) == 2'b01 && !($past(tick) && $past(at_top)))
        |-> $stable(active_q));

    // R5
    pwm_bot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wave_mode) == 2'b11 && !($past(tick) && $past(at_bottom)))
        |-> $stable(active_q));

    logic unused_ok;
    assign unused_ok = cnt_wr;
endmodule

bind ocu_channel ocu_chk #(.CW(CW)) u_ocu_chk (
    .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr),
    .wave_mode(wave_mode), .at_top(at_top), .at_bottom(at_bottom),
    .match_flag(match_flag), .clr_req(clr_req),
    .blk_q(blk_q), .active_q(active_q)
);

// File: tb/ocu_channel_bench.sv
module ocu_channel_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] cnt = 8'd0;
    logic       at_top = 1'b0;
    logic       at_bottom = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [1:0] wave_mode = 2'b00;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       match_flag;
    logic       wave_out;
    logic       clr_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ocu_channel u_ocu_channel (
        .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .at_top(at_top),
        .at_bottom(at_bottom), .cnt_wr(cnt_wr), .wave_mode(wave_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .match_flag(match_flag),
        .wave_out(wave_out), .clr_req(clr_req)
    );

    // {out_mode[1:0], cmp[7:0], cnt[7:0], exp_flag, exp_out}
    localparam logic [19:0] VEC [8] = '{
        {2'b01, 8'd10,  8'd10,  1'b1, 1'b1},
        {2'b01, 8'd10,  8'd11,  1'b0, 1'b1},
        {2'b01, 8'd20,  8'd20,  1'b1, 1'b0},
        {2'b11, 8'd5,   8'd5,   1'b1, 1'b1},
        {2'b11, 8'd5,   8'd5,   1'b1, 1'b1},
        {2'b10, 8'd255, 8'd255, 1'b1, 1'b0},
        {2'b10, 8'd0,   8'd1,   1'b0, 1'b0},
        {2'b00, 8'd7,   8'd7,   1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic [7:0] c, input logic top, input logic bot);
        tick = 1'b1; cnt = c; at_top = top; at_bottom = bot;
        @(negedge clk);
        tick = 1'b0; at_top = 1'b0; at_bottom = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd_addr = 2'd0;
        #1 check("reset rd cmp", rd_data, 8'd0);
        check("reset flag", {7'd0, match_flag}, 8'd0);
        check("reset out", {7'd0, wave_out}, 8'd0);

        // R1 R2 R3: vector walk in normal mode
        for (int i = 0; i < 8; i++) begin
            wr(2'd1, {6'd0, VEC[i][19:18]});
            wr(2'd0, VEC[i][17:10]);
            wr(2'd2, 8'd1);
            rd_addr = 2'd0;
            #1 check("R3 direct read", rd_data, VEC[i][17:10]);
            step(VEC[i][9:2], 1'b0, 1'b0);
            check("R1 flag", {7'd0, match_flag}, {7'd0, VEC[i][1]});
            check("R2 out", {7'd0, wave_out}, {7'd0, VEC[i][0]});
        end

        // R6 force in normal mode
        wr(2'd2, 8'd1);
        wr(2'd1, 8'h07);
        check("R6 force set", {7'd0, wave_out}, 8'd1);
        check("R6 force no flag", {7'd0, match_flag}, 8'd0);
        check("R6 force no clr", {7'd0, clr_req}, 8'd0);
        rd_addr = 2'd1;
        #1 check("R6 force reads 0", rd_data, 8'h03);

        // R6 force in clear-on-compare mode
        wave_mode = 2'b10;
        wr(2'd1, 8'h06);
        check("R6 ctc force clear", {7'd0, wave_out}, 8'd0);
        check("R6 ctc no clr", {7'd0, clr_req}, 8'd0);
        check("R6 ctc no flag", {7'd0, match_flag}, 8'd0);

        // R7 force ignored in PWM
        wave_mode = 2'b01;
        wr(2'd1, 8'h07);
        check("R7 pwm force ignored", {7'd0, wave_out}, 8'd0);

        // R9 mode change keeps output
        wave_mode = 2'b00;
        wr(2'd1, 8'h07);
        wave_mode = 2'b11;
        @(negedge clk);
        check("R9 keep out", {7'd0, wave_out}, 8'd1);

        // R4 load at TOP (active is 7)
        wave_mode = 2'b01;
        wr(2'd0, 8'd50);
        rd_addr = 2'd0;
        #1 check("R4 read shadow", rd_data, 8'd50);
        wr(2'd2, 8'd1);
        step(8'd50, 1'b0, 1'b0);
        check("R4 no early load", {7'd0, match_flag}, 8'd0);
        step(8'd200, 1'b1, 1'b0);
        check("R4 top tick", {7'd0, match_flag}, 8'd0);
        step(8'd50, 1'b0, 1'b0);
        check("R4 loaded match", {7'd0, match_flag}, 8'd1);

        // R10 mode bits immediate while compare buffered
        wr(2'd1, 8'h02);
        step(8'd50, 1'b0, 1'b0);
        check("R10 immediate clear", {7'd0, wave_out}, 8'd0);

        // R5 load at BOTTOM
        wave_mode = 2'b11;
        wr(2'd1, 8'h03);
        wr(2'd0, 8'd60);
        wr(2'd2, 8'd1);
        step(8'd60, 1'b1, 1'b0);
        check("R5 top no load", {7'd0, match_flag}, 8'd0);
        step(8'd0, 1'b0, 1'b1);
        check("R5 bottom tick", {7'd0, match_flag}, 8'd0);
        step(8'd60, 1'b0, 1'b0);
        check("R5 loaded match", {7'd0, match_flag}, 8'd1);
        check("R5 set out", {7'd0, wave_out}, 8'd1);
        wave_mode = 2'b00;
        rd_addr = 2'd0;
        #1 check("R3 active read", rd_data, 8'd60);

        // R11 flag clearing
        wr(2'd2, 8'd0);
        check("R11 write0 keeps", {7'd0, match_flag}, 8'd1);
        wr(2'd2, 8'd1);
        check("R11 write1 clears", {7'd0, match_flag}, 8'd0);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd1;
        step(8'd60, 1'b0, 1'b0);
        wr_en = 1'b0;
        check("R11 set wins", {7'd0, match_flag}, 8'd1);

        // R12 clear request
        wave_mode = 2'b10;
        wr(2'd0, 8'd40);
        step(8'd40, 1'b0, 1'b0);
        check("R12 clr pulse", {7'd0, clr_req}, 8'd1);
        @(negedge clk);
        check("R12 clr one cycle", {7'd0, clr_req}, 8'd0);
        wave_mode = 2'b00;
        step(8'd40, 1'b0, 1'b0);
        check("R12 no clr normal", {7'd0, clr_req}, 8'd0);

        // R8 counter write blocks next tick
        wr(2'd0, 8'd30);
        wr(2'd2, 8'd1);
        cnt_wr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
        repeat (3) @(negedge clk);
        step(8'd30, 1'b0, 1'b0);
        check("R8 blocked", {7'd0, match_flag}, 8'd0);
        step(8'd30, 1'b0, 1'b0);
        check("R8 next matches", {7'd0, match_flag}, 8'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule